// File: doc/BRIEF.md
# Comparator-Driven LSB-First Tracking Converter

This block turns a single-bit comparator and an external resistor-ladder DAC into an analog-to-digital converter. It drives a 5-bit code onto the ladder, waits for the ladder and comparator to settle, and reads whether the analog input sits above the ladder voltage. From a run of these decisions it builds a 5-bit sample of the input. It is intended for slowly moving signals such as the sine outputs of an optical encoder, where consecutive samples lie close together.

The search does not run MSB-first like a classic successive-approximation converter. Every conversion starts at the previous result and takes a 1-LSB step toward the comparator's side. While the comparator keeps the same answer, the step doubles. After the first reversal the step halves on each decision. The conversion ends when a 1-LSB move reverses the comparator, or when the code reaches a rail with the comparator pointing past it. When the input holds still, each new sample costs only two decisions. A programmable settle count sets the pace of each decision, so the search can be slowed far enough to watch it on an oscilloscope.

Top module: `lsbtrk_adc`

## Requirements
- R1: While reset is held and after it is released, with enable low, dac_code is 0, sample is 0 and sample_valid is 0.
- R2: cmp_in = 1 means the analog input is above the current ladder level. For an input level L in 0..32, the comparator reads 1 exactly when dac_code < L. Every conversion returns the largest code at which the comparator reads 1, or 0 if there is no such code. That value is max(L-1, 0).
- R3: The first move of each conversion, if the code moves at all, is exactly 1 LSB away from the previous result. The move is upward when cmp_in = 1 and downward when cmp_in = 0.
- R4: While the comparator keeps the same polarity, the step doubles on each decision, up to 16. Starting from 0 with the comparator always 1, dac_code takes the values 1, 3, 7, 15, 31 in that order.
- R5: dac_code saturates at 0 and 31 and never wraps. A conversion with the comparator always 1 never lowers the code, and a conversion with the comparator always 0 never raises it.
- R6: Each conversion restarts from the previous result. With a steady input, every conversion after the first takes one decision period when the result sits at a rail and the comparator points past it, and two decision periods otherwise.
- R7: One decision period lasts settle_cycles + 3 clocks. Counted from the clock that accepts enable, changes of dac_code and pulses of sample_valid occur only at whole multiples of that period.
- R8: sample_valid is a one-cycle pulse. sample holds the new result in that cycle, and dac_code equals sample in that cycle.
- R9: When enable falls, the conversion in progress finishes and reports its result. After that there are no further sample_valid pulses, and dac_code and sample stay fixed whatever the comparator does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs conversions back to back while high |
| settle_cycles | input | SETTLE_W | Extra clocks of settling per decision |
| cmp_in | input | 1 | Asynchronous comparator output, 1 = input above ladder |
| dac_code | output | DAC_W | Code driven onto the resistor ladder |
| sample | output | DAC_W | Most recent conversion result |
| sample_valid | output | 1 | One-cycle strobe for a new result |

## Verification
Each decision is taken on the clock edge that closes a period of settle_cycles + 3 clocks. That period covers the two synchronizer flops, the settle count and the decision cycle itself, so ladder moves and result strobes are due only on multiples of it, counted from the clock that accepts enable. The bench drives the comparator combinationally from dac_code and changes the input level on the falling edge at which a strobe is first seen. The new level therefore reaches the second synchronizer flop before the next conversion's first decision, even at the shortest period of three clocks. All checks are made on falling edges, and the spacing and restart-cost checks count falling edges between events and compare them against whole periods.

// File: rtl/lsbtrk_pkg.sv
package lsbtrk_pkg;

    // Converter activity: waiting for enable, or stepping through decisions.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

endpackage

// File: rtl/lsbtrk_sync.sv
module lsbtrk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lsbtrk_pace.sv
module lsbtrk_pace #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] span,
    output logic             due
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pace_t;

    pace_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (restart)
            p_d.cnt = span;
        else if (p_q.cnt != '0)
            p_d.cnt = p_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign due = (p_q.cnt == '0);

    AST_SETTLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (p_q.cnt == $past(span))); // R7

    AST_NO_EARLY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && span != '0) |=> !due); // R7

endmodule

// File: rtl/lsbtrk_search.sv
module lsbtrk_search
    import lsbtrk_pkg::*;
#(
    parameter int DAC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cmp_s,
    input  logic             due,
    output logic             arm,
    output logic [DAC_W-1:0] code,
    output logic [DAC_W-1:0] result,
    output logic             valid
);

    localparam logic [DAC_W-1:0] CODE_MAX = '1;
    localparam logic [DAC_W-1:0] STEP_ONE = DAC_W'(1);
    localparam logic [DAC_W-1:0] STEP_TOP = DAC_W'(1) << (DAC_W - 1);

    typedef struct packed {
        phase_t           phase;
        logic [DAC_W-1:0] code;
        logic [DAC_W-1:0] step;
        logic [DAC_W-1:0] result;
        logic             above;
        logic             first;
        logic             narrow;
        logic             valid;
    } eng_t;

    eng_t s_d, s_q;

    logic             decide;
    logic             at_rail;
    logic             flipped;
    logic             finish;
    logic [DAC_W-1:0] picked;
    logic [DAC_W:0]   doubled;
    logic [DAC_W-1:0] grown;
    logic [DAC_W-1:0] halved;
    logic [DAC_W-1:0] nstep;
    logic [DAC_W:0]   up_sum;
    logic [DAC_W-1:0] up_code;
    logic [DAC_W-1:0] down_code;

    // Decision helpers: rail detection, polarity change, next step size.
    always_comb begin
        decide    = (s_q.phase == PH_RUN) && due;
        at_rail   = cmp_s ? (s_q.code == CODE_MAX) : (s_q.code == '0);
        flipped   = !s_q.first && (cmp_s != s_q.above);
        finish    = at_rail || (flipped && s_q.step == STEP_ONE);
        picked    = (at_rail || cmp_s) ? s_q.code : s_q.code - 1'b1;

        doubled   = {s_q.step, 1'b0};
        grown     = (doubled > {1'b0, STEP_TOP}) ? STEP_TOP : doubled[DAC_W-1:0];
        halved    = ((s_q.step >> 1) == '0) ? STEP_ONE : (s_q.step >> 1);
        if (s_q.first)
            nstep = STEP_ONE;
        else if (flipped || s_q.narrow)
            nstep = halved;
        else
            nstep = grown;

        up_sum    = {1'b0, s_q.code} + {1'b0, nstep};
        up_code   = up_sum[DAC_W] ? CODE_MAX : up_sum[DAC_W-1:0];
        down_code = (s_q.code < nstep) ? '0 : s_q.code - nstep;
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        arm       = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (enable) begin
                    s_d.phase  = PH_RUN;
                    s_d.first  = 1'b1;
                    s_d.narrow = 1'b0;
                    s_d.step   = STEP_ONE;
                    arm        = 1'b1;
                end
            end
            PH_RUN: begin
                if (decide) begin
                    if (finish) begin
                        s_d.result = picked;
                        s_d.code   = picked;
                        s_d.valid  = 1'b1;
                        s_d.first  = 1'b1;
                        s_d.narrow = 1'b0;
                        s_d.step   = STEP_ONE;
                        if (enable) arm = 1'b1;
                        else        s_d.phase = PH_IDLE;
                    end else begin
                        s_d.step   = nstep;
                        s_d.code   = cmp_s ? up_code : down_code;
                        s_d.above  = cmp_s;
                        s_d.first  = 1'b0;
                        s_d.narrow = s_q.narrow | flipped;
                        arm        = 1'b1;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase  <= PH_IDLE;
            s_q.code   <= '0;
            s_q.step   <= STEP_ONE;
            s_q.result <= '0;
            s_q.above  <= 1'b0;
            s_q.first  <= 1'b1;
            s_q.narrow <= 1'b0;
            s_q.valid  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code   = s_q.code;
    assign result = s_q.result;
    assign valid  = s_q.valid;

    AST_ONE_SHOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> !s_q.valid); // R8

    AST_RESTART_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> (s_q.code == s_q.result)); // R6

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.code != $past(s_q.code)) |->
        (((s_q.code > $past(s_q.code)) ? (s_q.code - $past(s_q.code))
                                       : ($past(s_q.code) - s_q.code)) <= STEP_TOP)); // R5

    AST_FIRST_MOVE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && s_q.first && !finish) |=>
        (((s_q.code > $past(s_q.code)) ? (s_q.code - $past(s_q.code))
                                       : ($past(s_q.code) - s_q.code)) == STEP_ONE)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE && $past(s_q.phase) == PH_IDLE) |-> $stable(s_q.code)); // R9

endmodule

// File: rtl/lsbtrk_adc.sv
module lsbtrk_adc #(
    parameter int DAC_W       = 5,
    parameter int SETTLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                cmp_in,
    output logic [DAC_W-1:0]    dac_code,
    output logic [DAC_W-1:0]    sample,
    output logic                sample_valid
);

    localparam int CNT_W = SETTLE_W + 1;

    logic             cmp_s;
    logic             due;
    logic             arm;
    logic [CNT_W-1:0] span;

    // Each decision waits for the synchronizer plus the programmed settling.
    assign span = CNT_W'(settle_cycles) + CNT_W'(SYNC_STAGES);

    lsbtrk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_in),
        .q     (cmp_s)
    );

    lsbtrk_pace #(.CNT_W(CNT_W)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm),
        .span    (span),
        .due     (due)
    );

    lsbtrk_search #(.DAC_W(DAC_W)) u_search (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .cmp_s  (cmp_s),
        .due    (due),
        .arm    (arm),
        .code   (dac_code),
        .result (sample),
        .valid  (sample_valid)
    );

    AST_STROBE_MATCHES_LADDER: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (dac_code == sample)); // R8

endmodule

// File: tb/lsbtrk_adc_test.sv
module lsbtrk_adc_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic [7:0] settle_cycles;
    logic       cmp_in;
    logic [4:0] dac_code;
    logic [4:0] sample;
    logic       sample_valid;

    int level;
    int checks, fails;
    int since_evt, per;
    bit mod_en, last_valid, log_en;
    int log_codes[32];
    int log_n;
    logic [4:0] prev_dac;

    always #4 clk = ~clk;

    // Comparator model: input above the ladder whenever code < level.
    always_comb cmp_in = (level > int'(dac_code));

    lsbtrk_adc uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .settle_cycles (settle_cycles),
        .cmp_in        (cmp_in),
        .dac_code      (dac_code),
        .sample        (sample),
        .sample_valid  (sample_valid)
    );

    function automatic int expect_of(input int lv);
        return (lv > 0) ? lv - 1 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int res, output int ncyc);
        ncyc = 0;
        res  = -1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            ncyc++;
            since_evt++;
            if (last_valid) begin
                check(!sample_valid, "R8 strobe width", int'(sample_valid), 0);
                last_valid = 1'b0;
            end
            if (dac_code != prev_dac || sample_valid) begin
                if (mod_en)
                    check((since_evt % per) == 0, "R7 decision spacing", since_evt, per);
                since_evt = 0;
            end
            if (dac_code != prev_dac && log_en && log_n < 32) begin
                log_codes[log_n] = int'(dac_code);
                log_n++;
            end
            prev_dac = dac_code;
            if (sample_valid) begin
                check(dac_code == sample, "R8 ladder equals sample", int'(dac_code), int'(sample));
                res = int'(sample);
                last_valid = 1'b1;
                return;
            end
        end
        check(1'b0, "R2 conversion timeout", ncyc, 4000);
    endtask

    task automatic start_run(input int settle);
        @(negedge clk);
        settle_cycles = 8'(settle);
        per           = settle + 3;
        enable        = 1'b1;
        since_evt     = -1;
        mod_en        = 1'b1;
        prev_dac      = dac_code;
        last_valid    = 1'b0;
    endtask

    task automatic stop_run();
        int r, n;
        enable = 1'b0;
        mod_en = 1'b0;
        wait_valid(r, n);
        repeat (4) @(negedge clk);
        last_valid = 1'b0;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r, n, start, c_first, expf;
        bit mono;
        checks = 0; fails = 0; log_en = 1'b0; log_n = 0; mod_en = 1'b0;
        last_valid = 1'b0; since_evt = 0; per = 3;
        rst_n = 1'b0; enable = 1'b0; settle_cycles = '0; level = 0;
        repeat (3) @(negedge clk);
        // R1: reset state, during and after reset
        check(dac_code == 0, "R1 dac at reset", int'(dac_code), 0);
        check(sample == 0, "R1 sample at reset", int'(sample), 0);
        check(!sample_valid, "R1 strobe at reset", int'(sample_valid), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(dac_code == 0 && sample == 0 && !sample_valid, "R1 idle after reset",
              int'(dac_code) + int'(sample) + int'(sample_valid), 0);

        // Exhaustive sweep of previous result x new level at the shortest period.
        start_run(0);
        wait_valid(r, n);
        check(r == 0, "R2 first conversion", r, 0);
        for (int s = 0; s <= 32; s++) begin
            for (int t = 0; t <= 32; t++) begin
                level = s;
                wait_valid(r, n);
                check(r == expect_of(s), "R2 settle to start level", r, expect_of(s));
                start = expect_of(s);
                level = t;
                log_n = 0;
                log_en = 1'b1;
                wait_valid(r, n);
                log_en = 1'b0;
                check(r == expect_of(t), "R2 converted value", r, expect_of(t));
                c_first = (t > start) ? 1 : 0;
                if (!((c_first == 1 && start == 31) || (c_first == 0 && start == 0))) begin
                    expf = (c_first == 1) ? start + 1 : start - 1;
                    check(log_n > 0 && log_codes[0] == expf, "R3 first move one LSB",
                          (log_n > 0) ? log_codes[0] : -1, expf);
                end
                if (t == 32 || t == 0) begin
                    mono = 1'b1;
                    for (int k = 0; k < log_n; k++) begin
                        if (t == 32 && log_codes[k] < ((k == 0) ? start : log_codes[k-1])) mono = 1'b0;
                        if (t == 0  && log_codes[k] > ((k == 0) ? start : log_codes[k-1])) mono = 1'b0;
                    end
                    check(mono, "R5 no wrap at rail", int'(mono), 1);
                end
            end
        end

        // R4: doubling steps from 0 with the comparator always high.
        level = 0;
        wait_valid(r, n);
        level = 32;
        log_n = 0;
        log_en = 1'b1;
        wait_valid(r, n);
        log_en = 1'b0;
        check(r == 31, "R4 ends at top rail", r, 31);
        check(log_n == 5, "R4 number of moves", log_n, 5);
        for (int k = 0; k < 5; k++)
            check(log_codes[k] == (1 << (k + 1)) - 1, "R4 doubling sequence",
                  log_codes[k], (1 << (k + 1)) - 1);
        stop_run();

        // R6/R7: restart cost with a steady input at slower paces.
        for (int sv = 3; sv <= 5; sv += 2) begin
            start_run(sv);
            for (int t = 0; t <= 32; t++) begin
                level = t;
                wait_valid(r, n);
                check(r == expect_of(t), "R2 slow pace value", r, expect_of(t));
                wait_valid(r, n);
                expf = (t >= 1 && t <= 31) ? 2 * per : per;
                check(n == expf, "R6 steady restart cost", n, expf);
                check(r == expect_of(t), "R6 steady result", r, expect_of(t));
            end
            stop_run();
        end

        // R9: dropping enable finishes the running conversion, then holds.
        start_run(1);
        level = 9;
        wait_valid(r, n);
        level = 20;
        wait_valid(r, n);
        check(r == 19, "R9 pre-stop value", r, 19);
        enable = 1'b0;
        mod_en = 1'b0;
        wait_valid(r, n);
        check(r == 19, "R9 running conversion completes", r, 19);
        @(negedge clk);
        level = 5;
        prev_dac = dac_code;
        begin
            bit quiet;
            quiet = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (sample_valid || dac_code != prev_dac || sample != 5'd19) quiet = 1'b0;
            end
            check(quiet, "R9 idle holds outputs", int'(quiet), 1);
        end
        check(int'(sample) == 19, "R9 sample held", int'(sample), 19);
        start_run(1);
        wait_valid(r, n);
        check(r == 4, "R9 resume after enable", r, 4);
        stop_run();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule